// File: doc/BRIEF.md
# Load Response Duty Tracker

This block picks the source of the gate enable for a field-current regulator. Each measurement period ends with a wrap strobe. Over each period the block counts how many clocks the analog comparator's PWM bit was high. A saturating level index follows that measured duty one step at a time and selects one of eleven stepped digital duty waveforms. Line k of these waveforms carries a duty of (5+k)/16. A programmable prescaler spaces the steps out. An acceleration input makes the steps 16 times more frequent.

A three-state controller decides which source drives the gate. ST_START is the power-up state. In it the selected digital waveform always drives the gate. The controller leaves ST_START at the end of the first period whose high count is below the full period length, that is, the first period in which the analog duty is under 100 %. It goes to ST_DIRECT if the high-engine-speed flag is set and to ST_TRACK otherwise. After that, ST_TRACK moves to ST_DIRECT when the flag rises, and ST_DIRECT moves to ST_TRACK when the flag falls. In ST_DIRECT the comparator bit drives the gate directly. ST_START is entered again only through reset. The level index keeps following the analog duty in every state.

Top module: `load_resp_duty_tracker`

## Requirements
- R1: After reset, duty_level is 0 and the controller is in ST_START.
- R2: In ST_START, gate_en equals duty_lines[duty_level] whatever the values of above_f2 and cmp_pwm.
- R3: ST_START is left on the period_wrap cycle whose period high count is below CYC_LEN. It is never entered again without a reset.
- R4: Once ST_START has been left, and while above_f2 has been 1 for the current and the previous cycle, gate_en equals cmp_pwm.
- R5: Once ST_START has been left, and while above_f2 has been 0 for the current and the previous cycle, gate_en equals duty_lines[duty_level]. Bit k of duty_lines is the waveform of duty (5+k)/16.
- R6: On a step tick, duty_level rises by 1 if the period high count is above (5+duty_level)*CYC_LEN/16, falls by 1 if it is below, and holds if it is equal. This happens in every state.
- R7: duty_level saturates at 0 and at LEVELS-1.
- R8: Ticks happen only on period_wrap cycles. A tick falls on every (rate_div+1)-th wrap when accel is 1 and on every 16*(rate_div+1)-th wrap when accel is 0. duty_level changes at no other time.
- R9: The period high count includes the cmp_pwm value of the wrap cycle itself and restarts from 0 after each wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_pwm | input | 1 | Analog duty comparator bit |
| duty_lines | input | LEVELS | Stepped digital duty waveforms, bit k = (5+k)/16 |
| above_f2 | input | 1 | Phase frequency is above the upper threshold |
| period_wrap | input | 1 | Last clock of a measurement period |
| accel | input | 1 | Step ticks 16 times faster |
| rate_div | input | DIV_W | Prescaler value N, ticks every N+1 units |
| gate_en | output | 1 | Gate drive enable |
| duty_level | output | LVL_W | Current selected duty level |

## Verification
The bench builds the block with CYC_LEN=32 and keeps LEVELS=11 and DIV_W=4. With a 32-clock period the thresholds become 10+2k, so the tests can hit a count exactly on a threshold, one above it and one below it. They can also ride the level from 0 to 10 and back, and run the slow 16-wrap tick mode, all within a few thousand clocks. A tail-loaded high pattern makes a step depend on the wrap-cycle sample, which isolates R9.

// File: rtl/lrdt_pkg.sv
package lrdt_pkg;

    typedef enum logic [1:0] {
        ST_START  = 2'd0,
        ST_TRACK  = 2'd1,
        ST_DIRECT = 2'd2
    } mode_e;

    typedef enum logic [1:0] {
        DIR_HOLD = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DOWN = 2'd2
    } step_dir_e;

endpackage

// File: rtl/lrdt_duty_meter.sv
module lrdt_duty_meter #(
    parameter int CYC_LEN = 256,
    localparam int CNT_W = $clog2(CYC_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_pwm,
    input  logic             period_wrap,
    output logic [CNT_W-1:0] period_total
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(CYC_LEN);

    logic [CNT_W-1:0] hi_q;

    // the wrap cycle's own sample is part of the closing period
    assign period_total = hi_q + {{(CNT_W-1){1'b0}}, cmp_pwm};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '0;
        end else if (period_wrap) begin
            hi_q <= '0;
        end else if (hi_q != FULL) begin
            hi_q <= period_total;
        end
    end
endmodule

// File: rtl/lrdt_rate_prescaler.sv
module lrdt_rate_prescaler #(
    parameter int DIV_W       = 4,
    parameter int ACCEL_SHIFT = 4,
    localparam int PS_W = DIV_W + ACCEL_SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             period_wrap,
    input  logic             accel,
    input  logic [DIV_W-1:0] rate_div,
    output logic             tick
);
    logic [PS_W-1:0] cnt_q;
    logic [PS_W-1:0] term;

    // last wrap of a group: N in fast mode, N*16+15 in slow mode
    always_comb begin
        if (accel) term = {{ACCEL_SHIFT{1'b0}}, rate_div};
        else       term = {rate_div, {ACCEL_SHIFT{1'b1}}};
    end

    assign tick = period_wrap && (cnt_q >= term);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (period_wrap) begin
            cnt_q <= tick ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/lrdt_level_stepper.sv
module lrdt_level_stepper
    import lrdt_pkg::*;
#(
    parameter int CYC_LEN = 256,
    parameter int LEVELS  = 11,
    parameter int BASE    = 5,
    localparam int CNT_W = $clog2(CYC_LEN + 1),
    localparam int LVL_W = $clog2(LEVELS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] period_total,
    output logic [LVL_W-1:0] level
);
    localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(LEVELS - 1);

    logic [CNT_W-1:0] thr;
    step_dir_e        dir;

    always_comb begin
        thr = CNT_W'(((BASE + int'(level)) * CYC_LEN) / 16);
        if (period_total > thr)      dir = DIR_UP;
        else if (period_total < thr) dir = DIR_DOWN;
        else                         dir = DIR_HOLD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level <= '0;
        end else if (tick) begin
            unique case (dir)
                DIR_UP:   if (level != TOP_LVL) level <= level + 1'b1;
                DIR_DOWN: if (level != '0)      level <= level - 1'b1;
                default:  level <= level;
            endcase
        end
    end
endmodule

// File: rtl/load_resp_duty_tracker.sv
module load_resp_duty_tracker
    import lrdt_pkg::*;
#(
    parameter int CYC_LEN     = 256,
    parameter int LEVELS      = 11,
    parameter int DIV_W       = 4,
    parameter int ACCEL_SHIFT = 4,
    localparam int CNT_W = $clog2(CYC_LEN + 1),
    localparam int LVL_W = $clog2(LEVELS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_pwm,
    input  logic [LEVELS-1:0] duty_lines,
    input  logic              above_f2,
    input  logic              period_wrap,
    input  logic              accel,
    input  logic [DIV_W-1:0]  rate_div,
    output logic              gate_en,
    output logic [LVL_W-1:0]  duty_level
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(CYC_LEN);

    logic [CNT_W-1:0] period_total;
    logic             tick;
    mode_e            state, state_nx;

    lrdt_duty_meter #(.CYC_LEN(CYC_LEN)) u_meter (
        .clk(clk), .rst_n(rst_n), .cmp_pwm(cmp_pwm),
        .period_wrap(period_wrap), .period_total(period_total)
    );

    lrdt_rate_prescaler #(.DIV_W(DIV_W), .ACCEL_SHIFT(ACCEL_SHIFT)) u_presc (
        .clk(clk), .rst_n(rst_n), .period_wrap(period_wrap),
        .accel(accel), .rate_div(rate_div), .tick(tick)
    );

    lrdt_level_stepper #(.CYC_LEN(CYC_LEN), .LEVELS(LEVELS)) u_step (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .period_total(period_total), .level(duty_level)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_START:  if (period_wrap && period_total < FULL)
                           state_nx = above_f2 ? ST_DIRECT : ST_TRACK;
            ST_TRACK:  if (above_f2)  state_nx = ST_DIRECT;
            ST_DIRECT: if (!above_f2) state_nx = ST_TRACK;
            default:   state_nx = ST_START;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_START;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            ST_DIRECT: gate_en = cmp_pwm;
            default:   gate_en = duty_lines[duty_level];
        endcase
    end
endmodule

// File: rtl/lrdt_checker.sv
module lrdt_checker
    import lrdt_pkg::*;
#(
    parameter int LEVELS = 11,
    localparam int LVL_W = $clog2(LEVELS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmp_pwm,
    input logic [LEVELS-1:0] duty_lines,
    input logic              above_f2,
    input logic              period_wrap,
    input logic              gate_en,
    input logic [LVL_W-1:0]  duty_level,
    input mode_e             state
);
    // R7
    level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(duty_level) <= LEVELS - 1);

    // R6
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_level != $past(duty_level)) |->
            (duty_level == $past(duty_level) + 1'b1 ||
             duty_level + 1'b1 == $past(duty_level)));

    // R8
    wrap_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(period_wrap) |-> $stable(duty_level));

    // R3
    no_reentry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) != ST_START) |-> (state != ST_START));

    // R4
    direct_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_START && above_f2 && $past(above_f2)) |-> (gate_en == cmp_pwm));

    // R5
    track_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!above_f2 && !$past(above_f2)) |-> (gate_en == duty_lines[duty_level]));
endmodule

bind load_resp_duty_tracker lrdt_checker #(.LEVELS(LEVELS)) u_lrdt_chk (
    .clk(clk), .rst_n(rst_n), .cmp_pwm(cmp_pwm), .duty_lines(duty_lines),
    .above_f2(above_f2), .period_wrap(period_wrap), .gate_en(gate_en),
    .duty_level(duty_level), .state(state)
);

// File: tb/test_load_resp_duty_tracker.sv
module test_load_resp_duty_tracker;
    localparam int CYC    = 32;
    localparam int LEVELS = 11;
    localparam int DIV_W  = 4;
    localparam int LVL_W  = $clog2(LEVELS);

    typedef struct {
        int    lvl;
        string tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmp_pwm = 1'b0;
    logic [LEVELS-1:0] duty_lines = '0;
    logic              above_f2 = 1'b1;
    logic              period_wrap = 1'b0;
    logic              accel = 1'b1;
    logic [DIV_W-1:0]  rate_div = '0;
    logic              gate_en;
    logic [LVL_W-1:0]  duty_level;

    int   checks = 0;
    int   failures = 0;
    exp_t exp_q[$];
    logic wrap_seen = 1'b0;
    int   m_lvl = 0;
    int   m_pcnt = 0;
    bit   m_reg = 0;
    bit   done = 0;

    always #4 clk = ~clk;

    load_resp_duty_tracker #(.CYC_LEN(CYC), .LEVELS(LEVELS), .DIV_W(DIV_W)) i_load_resp_duty_tracker (
        .clk(clk), .rst_n(rst_n), .cmp_pwm(cmp_pwm), .duty_lines(duty_lines),
        .above_f2(above_f2), .period_wrap(period_wrap), .accel(accel),
        .rate_div(rate_div), .gate_en(gate_en), .duty_level(duty_level)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // model of one period end, from the requirements
    task automatic model_wrap(input int h, input string tag);
        int  term;
        bit  tk;
        int  thr;
        exp_t e;
        term = accel ? int'(rate_div) : int'(rate_div) * 16 + 15;
        tk = (m_pcnt >= term);
        m_pcnt = tk ? 0 : m_pcnt + 1;
        thr = (5 + m_lvl) * CYC / 16;
        if (tk) begin
            if (h > thr && m_lvl < LEVELS - 1) m_lvl++;
            else if (h < thr && m_lvl > 0)     m_lvl--;
        end
        if (h < CYC) m_reg = 1;
        e.lvl = m_lvl;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    // driver: one period, h high clocks at its start or its end
    task automatic run_period(input int h, input bit at_end, input string tag);
        for (int c = 0; c < CYC; c++) begin
            @(negedge clk);
            cmp_pwm = at_end ? (c >= CYC - h) : (c < h);
            period_wrap = (c == CYC - 1);
            if (c == CYC - 1) model_wrap(h, tag);
        end
        @(negedge clk);
        period_wrap = 1'b0;
        cmp_pwm = 1'b0;
    endtask

    always @(posedge clk) wrap_seen <= period_wrap;

    // monitor: compare the level after every period end
    initial begin
        forever begin
            @(negedge clk);
            if (wrap_seen) begin
                if (exp_q.size() == 0) begin
                    chk(0, "queue", 0, 1);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(int'(duty_level) == e.lvl, e.tag, int'(duty_level), e.lvl);
                end
            end
        end
    end

    task automatic gate_chk(input logic c, input logic [LEVELS-1:0] l,
                            input logic exp, input string tag);
        cmp_pwm = c;
        duty_lines = l;
        #1;
        chk(gate_en == exp, tag, int'(gate_en), int'(exp));
    endtask

    initial begin
        #1600000;
        if (!done) begin
            chk(0, "watchdog", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(duty_level == '0, "R1 reset level", int'(duty_level), 0);
        rst_n = 1'b1;
        // R2: start state, flag high, gate follows line 0
        gate_chk(1'b0, 11'h001, 1'b1, "R2 start gate");
        gate_chk(1'b1, 11'h000, 1'b0, "R2 start gate");
        cmp_pwm = 1'b0;

        for (int i = 0; i < 3; i++) run_period(CYC, 0, "R6 up in start");
        gate_chk(1'b0, 11'h008, 1'b1, "R3 full duty keeps start");
        gate_chk(1'b1, 11'h000, 1'b0, "R3 full duty keeps start");
        cmp_pwm = 1'b0;

        run_period(CYC - 1, 0, "R6 up");
        gate_chk(1'b0, '1, 1'b0, "R4 direct gate");
        gate_chk(1'b1, '0, 1'b1, "R4 direct gate");
        cmp_pwm = 1'b0;

        above_f2 = 1'b0;
        @(negedge clk);
        gate_chk(1'b0, 11'h010, 1'b1, "R5 tracking gate");
        gate_chk(1'b1, ~11'h010, 1'b0, "R5 tracking gate");
        cmp_pwm = 1'b0;
        above_f2 = 1'b1;
        @(negedge clk);
        run_period(CYC, 0, "R6 up");
        gate_chk(1'b0, 11'h020, 1'b0, "R3 no return to start");
        cmp_pwm = 1'b0;
        above_f2 = 1'b0;

        // level 5, threshold 20
        run_period(20, 0, "R6 hold at equal");
        run_period(19, 0, "R6 down");
        run_period(19, 0, "R6 up");
        run_period(21, 1, "R9 wrap sample counted");
        run_period(22, 1, "R9 hold at equal");

        for (int i = 0; i < 6; i++) run_period(CYC, 0, "R7 top saturation");
        for (int i = 0; i < 12; i++) run_period(0, 0, "R7 bottom saturation");

        rate_div = 4'd2;
        for (int i = 0; i < 6; i++) run_period(CYC, 0, "R8 fast divide");
        accel = 1'b0;
        rate_div = 4'd0;
        for (int i = 0; i < 32; i++) run_period(CYC, 0, "R8 slow divide");

        above_f2 = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        chk(duty_level == '0, "R1 reset level", int'(duty_level), 0);
        rst_n = 1'b1;
        gate_chk(1'b0, 11'h001, 1'b1, "R1 reset start state");
        cmp_pwm = 1'b0;
        @(negedge clk);
        chk(exp_q.size() == 0, "queue drained", exp_q.size(), 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule